// File: doc/BRIEF.md
# Working Register File with Upper-Half and Pointer Addressing

This block is the working register file of a small 8-bit processor core. It holds thirty-two byte-wide registers. Two read ports return operands in the same cycle they are addressed, and one write port commits a result on the next rising clock edge. Decode logic outside the block picks an addressing mode separately for each port.

Full mode uses a 5-bit index that reaches any register. Upper mode serves instructions that carry a constant operand: its 4-bit index lands in registers 16 to 31 only. Pointer mode ignores the index and takes the register number from the contents of register 30. The block also drives the current contents of register 30 on a port of its own, so that surrounding logic can see the pointer value.

Top module: `wregfile_top`

## Requirements
- R1: The file holds 32 registers of 8 bits. In full mode (mode code 0), a 5-bit index selects that register directly.
- R2: Read data is combinational from the addressed register in the same cycle. A write with wr_en high is stored at the next rising clock edge.
- R3: In upper mode (mode code 1), index bits [3:0] select register 16 plus that value, and index bit 4 is ignored.
- R4: In pointer mode (mode code 2), the low 5 bits of register 30 select the register, and its upper 3 bits are ignored. This applies to the read ports and to the write port alike.
- R5: ptr_o always shows the stored contents of register 30. A write to register 30 appears on ptr_o from the cycle after the write edge.
- R6: A read of the register that is being written in the same cycle returns the old value.
- R7: When wr_en is low, no register changes, whatever wr_mode, wr_idx and wr_data hold.
- R8: When rst_n is low, every register is cleared to zero, asynchronously to the clock.
- R9: Mode code 3 addresses exactly like full mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 2 | Addressing mode of the write port |
| wr_idx | input | 5 | Register index of the write port |
| wr_data | input | 8 | Data to write |
| ra_mode | input | 2 | Addressing mode of read port A |
| ra_idx | input | 5 | Register index of read port A |
| rb_mode | input | 2 | Addressing mode of read port B |
| rb_idx | input | 5 | Register index of read port B |
| ra_data | output | 8 | Operand from read port A |
| rb_data | output | 8 | Operand from read port B |
| ptr_o | output | 8 | Current contents of register 30 |

## Verification
The assertions assume that the mode and index inputs are stable and known at each rising edge. They also assume that wr_en is never undefined after reset is released. The bench changes every input only on the falling clock edge, so all inputs are settled long before the next rising edge. Reset is driven low at the start and once more in the middle of the run, and neither time falls on a rising edge.

// File: rtl/wregfile_pkg.sv
package wregfile_pkg;
  typedef enum logic [1:0] {
    AM_FULL  = 2'd0,
    AM_UPPER = 2'd1,
    AM_PTR   = 2'd2,
    AM_ALT   = 2'd3
  } addr_mode_t;
endpackage

// File: rtl/wregfile_addr_map.sv
module wregfile_addr_map
  import wregfile_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  addr_mode_t    mode_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] ptr_i,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    unique case (mode_i)
      AM_UPPER: addr_o = {1'b1, idx_i[AW-2:0]};
      AM_PTR:   addr_o = ptr_i[AW-1:0];
      default:  addr_o = idx_i;
    endcase
  end
endmodule

// File: rtl/wregfile_store.sv
module wregfile_store #(
  parameter int NREGS   = 32,
  parameter int DW      = 8,
  parameter int NRD     = 2,
  parameter int PTR_IDX = 30,
  localparam int AW     = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][DW-1:0]   rd_data,
  output logic [DW-1:0]            ptr_q
);
  logic [NREGS-1:0][DW-1:0] regs_q;
  logic [NREGS-1:0][DW-1:0] regs_d;

  always_comb begin
    regs_d = regs_q;
    regs_d[wr_addr] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      regs_q <= regs_d;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = regs_q[rd_addr[p]];
  end

  assign ptr_q = regs_q[PTR_IDX];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(wr_addr)] == $past(wr_data)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q)); // R7
endmodule

// File: rtl/wregfile_top.sv
module wregfile_top
  import wregfile_pkg::*;
#(
  parameter int NREGS   = 32,
  parameter int DW      = 8,
  parameter int PTR_IDX = 30,
  localparam int AW     = $clog2(NREGS),
  localparam int NPORT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_mode,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    ra_mode,
  input  logic [AW-1:0] ra_idx,
  input  logic [1:0]    rb_mode,
  input  logic [AW-1:0] rb_idx,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data,
  output logic [DW-1:0] ptr_o
);
  // port 0 = write, 1 = read A, 2 = read B
  addr_mode_t [NPORT-1:0]         modes;
  logic       [NPORT-1:0][AW-1:0] idxs;
  logic       [NPORT-1:0][AW-1:0] addrs;
  logic       [1:0][DW-1:0]       rdata;
  logic       [DW-1:0]            ptr_q;

  assign modes[0] = addr_mode_t'(wr_mode);
  assign modes[1] = addr_mode_t'(ra_mode);
  assign modes[2] = addr_mode_t'(rb_mode);
  assign idxs[0]  = wr_idx;
  assign idxs[1]  = ra_idx;
  assign idxs[2]  = rb_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    wregfile_addr_map #(.DW(DW), .AW(AW)) map_i (
      .mode_i (modes[p]),
      .idx_i  (idxs[p]),
      .ptr_i  (ptr_q),
      .addr_o (addrs[p])
    );
  end

  wregfile_store #(
    .NREGS(NREGS), .DW(DW), .NRD(2), .PTR_IDX(PTR_IDX)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (addrs[0]),
    .wr_data (wr_data),
    .rd_addr ({addrs[2], addrs[1]}),
    .rd_data (rdata),
    .ptr_q   (ptr_q)
  );

  assign ra_data = rdata[0];
  assign rb_data = rdata[1];
  assign ptr_o   = ptr_q;

  AST_UPPER_EQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode == 2'd1 && rb_mode == 2'd0 && rb_idx == {1'b1, ra_idx[AW-2:0]})
    |-> ra_data == rb_data); // R3
  AST_PTR_EQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode == 2'd2 && rb_mode == 2'd0 && rb_idx == ptr_o[AW-1:0])
    |-> ra_data == rb_data); // R4
  AST_PTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addrs[0] == AW'(PTR_IDX)) |=> ptr_o == $past(wr_data)); // R5
  AST_ALT_EQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode == 2'd3 && rb_mode == 2'd0 && rb_idx == ra_idx)
    |-> ra_data == rb_data); // R9
endmodule

// File: tb/wregfile_top_tb_top.sv
module wregfile_top_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [1:0] wr_mode, ra_mode, rb_mode;
  logic [4:0] wr_idx, ra_idx, rb_idx;
  logic [7:0] wr_data;
  logic [7:0] ra_data, rb_data, ptr_o;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  wregfile_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_idx(wr_idx), .wr_data(wr_data), .ra_mode(ra_mode), .ra_idx(ra_idx),
    .rb_mode(rb_mode), .rb_idx(rb_idx), .ra_data(ra_data), .rb_data(rb_data),
    .ptr_o(ptr_o)
  );

  // we, wmode, widx, wdata, amode, aidx, bmode, bidx, expA, expB, expPtr
  localparam int NV = 10;
  localparam logic [53:0] VEC [NV] = '{
    // R1 R6: r5 written, read of r5 still old
    {1'b1, 2'd0, 5'd5,  8'h11, 2'd0, 5'd5,  2'd0, 5'd0,  8'h00, 8'h00, 8'h00},
    // R3: upper write, idx bit4 set ignored -> r18
    {1'b1, 2'd1, 5'h12, 8'h22, 2'd0, 5'd5,  2'd0, 5'd18, 8'h11, 8'h00, 8'h00},
    // R3 R5: r30 <= 0x13
    {1'b1, 2'd0, 5'd30, 8'h13, 2'd1, 5'd2,  2'd0, 5'd30, 8'h22, 8'h00, 8'h00},
    // R4 R6: pointer write to r19, pointer read old
    {1'b1, 2'd2, 5'd0,  8'h33, 2'd2, 5'd7,  2'd0, 5'd30, 8'h00, 8'h13, 8'h13},
    // R7: write disabled
    {1'b0, 2'd0, 5'd0,  8'hFF, 2'd0, 5'd19, 2'd2, 5'd0,  8'h33, 8'h33, 8'h13},
    // R7 R3: r0 untouched; r30 <= 0xE5
    {1'b1, 2'd0, 5'd30, 8'hE5, 2'd0, 5'd0,  2'd1, 5'd3,  8'h00, 8'h33, 8'h13},
    // R4 R9: pointer bits 7:5 ignored -> r5; mode 3 idx 5
    {1'b1, 2'd1, 5'h0F, 8'h77, 2'd2, 5'd0,  2'd3, 5'd5,  8'h11, 8'h11, 8'hE5},
    // R3: top of upper half is r31
    {1'b1, 2'd0, 5'd1,  8'h01, 2'd1, 5'd15, 2'd0, 5'd31, 8'h77, 8'h77, 8'hE5},
    // R4: pointer write to r5
    {1'b1, 2'd2, 5'd9,  8'h55, 2'd0, 5'd1,  2'd0, 5'd30, 8'h01, 8'hE5, 8'hE5},
    // R2 R4
    {1'b0, 2'd0, 5'd0,  8'h00, 2'd0, 5'd5,  2'd2, 5'd0,  8'h55, 8'h55, 8'hE5}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] am, input logic [4:0] ai,
                    input logic [1:0] bm, input logic [4:0] bi);
    ra_mode = am; ra_idx = ai; rb_mode = bm; rb_idx = bi;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_mode = 2'd0; wr_idx = '0; wr_data = '0;
    rd(2'd0, 5'd0, 2'd0, 5'd31);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 reset r0", ra_data, 8'h00);
    chk("R8 reset r31", rb_data, 8'h00);
    chk("R8 reset ptr", ptr_o, 8'h00);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      wr_en = VEC[k][53]; wr_mode = VEC[k][52:51]; wr_idx = VEC[k][50:46];
      wr_data = VEC[k][45:38];
      rd(VEC[k][37:36], VEC[k][35:31], VEC[k][30:29], VEC[k][28:24]);
      #1;
      chk($sformatf("vec%0d R1-port A", k), ra_data, VEC[k][23:16]);
      chk($sformatf("vec%0d R1-port B", k), rb_data, VEC[k][15:8]);
      chk($sformatf("vec%0d R5 ptr", k), ptr_o, VEC[k][7:0]);
    end

    // R3 boundary: upper idx 0 -> r16
    @(negedge clk);
    wr_en = 1'b1; wr_mode = 2'd1; wr_idx = 5'd0; wr_data = 8'hA0;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd0, 5'd16, 2'd0, 5'd0);
    #1;
    chk("R3 upper idx0 is r16", ra_data, 8'hA0);
    chk("R3 r0 untouched", rb_data, 8'h00);

    // R5: ptr_o changes only after the edge
    wr_en = 1'b1; wr_mode = 2'd0; wr_idx = 5'd30; wr_data = 8'h3C;
    #1;
    chk("R5 ptr before edge", ptr_o, 8'hE5);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R5 ptr after edge", ptr_o, 8'h3C);

    // R8: asynchronous reset mid-run, away from clock edges
    #2;
    rst_n = 1'b0;
    #1;
    rd(2'd0, 5'd5, 2'd0, 5'd16);
    #1;
    chk("R8 async r5", ra_data, 8'h00);
    chk("R8 async r16", rb_data, 8'h00);
    chk("R8 async ptr", ptr_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule